// File: doc/BRIEF.md
# Saturating 64-bit Accumulate Adder with Sticky Status

This block is the final accumulation stage of a multiply-add datapath that keeps its operands in 64-bit register pairs. On each qualified cycle it adds two signed 64-bit values. It returns either the modulo sum or a sum clamped to the signed range, depending on a per-operation mode bit. The result is registered and appears one clock after the request, together with a valid strobe.

Alongside the result the block reports four status bits. The overflow bit marks a signed overflow of the addition. The advance bit warns that the raw sum has left the range that its two top bits can hold as a sign. Each of these has a sticky companion that accumulates across operations until a clear pulse or reset drops it. The surrounding core reads the sticky bits to learn whether any operation in a sequence went wrong.

Top module: `sat_add64_acc`

## Requirements
- R1: With `sat_mode` = 0 (wrapping), `result` equals `op_a + op_b` modulo 2^64 on the cycle after `in_valid` was high.
- R2: `ovf` is 1 exactly when `op_a` and `op_b` have equal sign bits (bit 63) and bit 63 of the sum differs from that of `op_a`; an operation without overflow sets `ovf` to 0.
- R3: With `sat_mode` = 1, an overflowing operation whose `op_a` is non-negative yields `result` = 64'h7FFF_FFFF_FFFF_FFFF.
- R4: With `sat_mode` = 1, an overflowing operation whose `op_a` is negative yields `result` = 64'h8000_0000_0000_0000; without overflow the plain sum is returned in either mode.
- R5: `adv_ovf` equals bit 63 XOR bit 62 of the unclamped sum, in both modes.
- R6: `sticky_ovf` is the OR of its previous value and `ovf` of every operation since the last clear or reset.
- R7: `sticky_adv` is the OR of its previous value and `adv_ovf` of every operation since the last clear or reset.
- R8: A `clr_sticky` pulse sets both sticky bits to 0 on the next cycle; if `in_valid` is high in the same cycle, the sticky bits take that operation's flags. `ovf`, `adv_ovf` and `result` are not affected by the clear.
- R9: `out_valid` is high exactly one cycle after each cycle with `in_valid` high; while `in_valid` is low, `result`, `ovf` and `adv_ovf` hold their values.
- R10: After synchronous reset `rst`, `result`, all four flags and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operands and mode in this cycle |
| sat_mode | input | 1 | 1 = clamp on overflow, 0 = wrap |
| clr_sticky | input | 1 | Clears both sticky flags |
| op_a | input | 64 | First signed operand (its sign selects the clamp value) |
| op_b | input | 64 | Second signed operand |
| out_valid | output | 1 | Result and flags were updated this cycle |
| result | output | 64 | Registered sum |
| ovf | output | 1 | Signed overflow of the last operation |
| adv_ovf | output | 1 | Advance overflow of the last operation |
| sticky_ovf | output | 1 | Accumulated overflow |
| sticky_adv | output | 1 | Accumulated advance overflow |

## Verification
Every output is one register stage from its inputs, so the result, the two per-operation flags, the sticky bits and `out_valid` are all due on the first rising edge after the stimulus cycle. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. There each output is compared with values computed from the requirements. A clear pulse is checked the same way, one edge later. Hold behaviour is checked by letting further edges pass with `in_valid` low and comparing against the earlier sample.

// File: rtl/sat_add_pkg.sv
package sat_add_pkg;

    // Number of per-operation status bits that also have a sticky copy
    localparam int unsigned NUM_FLAGS = 2;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SAT  = 1'b1
    } add_mode_e;

    typedef struct packed {
        logic adv;
        logic ovf;
    } add_flags_t;

    // Largest signed value for a given width
    function automatic logic [63:0] max_pos64();
        return {1'b0, {63{1'b1}}};
    endfunction

endpackage

// File: rtl/sat_add_core.sv
module sat_add_core #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         adv
);
    localparam int unsigned MSB = W - 1;

    always_comb begin
        sum = a + b;
        // signs agree on the inputs but the sum leaves that sign
        ovf = ~(a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]);
        // top two bits of the raw sum disagree
        adv = sum[MSB] ^ sum[MSB-1];
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_add_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] raw,
    input  logic         ovf,
    input  add_mode_e    mode,
    input  logic         a_neg,
    output logic [W-1:0] clamped
);
    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (mode == MODE_SAT && ovf) begin
            clamped = a_neg ? NEG_LIMIT : POS_LIMIT;
        end else begin
            clamped = raw;
        end
    end
endmodule

// File: rtl/sat_sticky_bank.sv
module sat_sticky_bank #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         upd,
    input  logic [N-1:0] flag_in,
    output logic [N-1:0] sticky
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic held;
        always_ff @(posedge clk) begin
            if (rst) begin
                held <= 1'b0;
            end else begin
                held <= (held & ~clr) | (upd & flag_in[i]);
            end
        end
        assign sticky[i] = held;
    end
endmodule

// File: rtl/sat_add64_acc.sv
module sat_add64_acc
    import sat_add_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         sat_mode,
    input  logic         clr_sticky,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         adv_ovf,
    output logic         sticky_ovf,
    output logic         sticky_adv
);
    logic [W-1:0] raw_sum;
    logic [W-1:0] final_sum;
    add_flags_t   cur_flags;
    add_flags_t   flags_q;
    add_mode_e    mode;
    logic [NUM_FLAGS-1:0] sticky_vec;

    assign mode = add_mode_e'(sat_mode);

    sat_add_core #(.W(W)) u_core (
        .a   (op_a),
        .b   (op_b),
        .sum (raw_sum),
        .ovf (cur_flags.ovf),
        .adv (cur_flags.adv)
    );

    sat_clamp #(.W(W)) u_clamp (
        .raw     (raw_sum),
        .ovf     (cur_flags.ovf),
        .mode    (mode),
        .a_neg   (op_a[W-1]),
        .clamped (final_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            flags_q   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= final_sum;
                flags_q <= cur_flags;
            end
        end
    end

    sat_sticky_bank #(.N(NUM_FLAGS)) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_sticky),
        .upd     (in_valid),
        .flag_in (cur_flags),
        .sticky  (sticky_vec)
    );

    assign ovf        = flags_q.ovf;
    assign adv_ovf    = flags_q.adv;
    assign sticky_ovf = sticky_vec[0];
    assign sticky_adv = sticky_vec[1];
endmodule

// File: rtl/sat_add64_acc_chk.sv
module sat_add64_acc_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         sat_mode,
    input logic         clr_sticky,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         ovf,
    input logic         adv_ovf,
    input logic         sticky_ovf,
    input logic         sticky_adv
);
    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(ovf) && $stable(adv_ovf))); // R9
    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ovf && $past(sat_mode)) |-> (result == POS_LIMIT || result == NEG_LIMIT)); // R3
    AST_STICKY_OVF_COVERS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ovf) |-> sticky_ovf); // R6
    AST_STICKY_ADV_COVERS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && adv_ovf) |-> sticky_adv); // R7
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (sticky_ovf && !clr_sticky) |=> sticky_ovf); // R6
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_sticky && !in_valid) |=> (!sticky_ovf && !sticky_adv)); // R8
endmodule

bind sat_add64_acc sat_add64_acc_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .sat_mode   (sat_mode),
    .clr_sticky (clr_sticky),
    .op_a       (op_a),
    .op_b       (op_b),
    .out_valid  (out_valid),
    .result     (result),
    .ovf        (ovf),
    .adv_ovf    (adv_ovf),
    .sticky_ovf (sticky_ovf),
    .sticky_adv (sticky_adv)
);

// File: tb/sat_add64_acc_test.sv
module sat_add64_acc_test;
    localparam int W = 64;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         sat_mode;
    logic         clr_sticky;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         out_valid;
    logic [W-1:0] result;
    logic         ovf;
    logic         adv_ovf;
    logic         sticky_ovf;
    logic         sticky_adv;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench-side model of the sticky bits
    logic m_sov;
    logic m_sadv;

    always #2 clk = ~clk;

    sat_add64_acc #(.W(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sat_mode(sat_mode),
        .clr_sticky(clr_sticky), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .ovf(ovf), .adv_ovf(adv_ovf),
        .sticky_ovf(sticky_ovf), .sticky_adv(sticky_adv)
    );

    task automatic chk64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk1(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One operation: drive on falling edge, sample one rising edge later
    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic mode, input logic clr);
        logic [63:0] s, e_res;
        logic e_ovf, e_adv;
        s     = a + b;
        e_ovf = (a[63] == b[63]) && (s[63] != a[63]);
        e_adv = s[63] ^ s[62];
        e_res = (mode && e_ovf) ? (a[63] ? MINV : MAXV) : s;
        m_sov  = (clr ? 1'b0 : m_sov)  | e_ovf;
        m_sadv = (clr ? 1'b0 : m_sadv) | e_adv;
        op_a = a; op_b = b; sat_mode = mode; clr_sticky = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clr_sticky = 1'b0;
        chk1 (req, "out_valid", out_valid, 1'b1);
        chk64(req, "result", result, e_res);
        chk1 (req, "ovf", ovf, e_ovf);
        chk1 (req, "adv_ovf", adv_ovf, e_adv);
        chk1 (req, "sticky_ovf", sticky_ovf, m_sov);
        chk1 (req, "sticky_adv", sticky_adv, m_sadv);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; sat_mode = 1'b0; clr_sticky = 1'b0;
        op_a = '0; op_b = '0;
        m_sov = 1'b0; m_sadv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk1 ("R10", "out_valid", out_valid, 1'b0);
        chk64("R10", "result", result, 64'd0);
        chk1 ("R10", "ovf", ovf, 1'b0);
        chk1 ("R10", "adv_ovf", adv_ovf, 1'b0);
        chk1 ("R10", "sticky_ovf", sticky_ovf, 1'b0);
        chk1 ("R10", "sticky_adv", sticky_adv, 1'b0);
    endtask

    task automatic t_wrap_plain();
        run_op("R1", 64'd5, -64'sd7, 1'b0, 1'b0);
        run_op("R1", 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 1'b0, 1'b0);
        run_op("R4", 64'd100, 64'd23, 1'b1, 1'b0);   // saturating, no overflow: plain sum
    endtask

    task automatic t_wrap_overflow();
        run_op("R2", MAXV, 64'd1, 1'b0, 1'b0);        // wraps to MINV
        run_op("R2", 64'd1, 64'd2, 1'b0, 1'b0);       // ovf cleared
        run_op("R2", MINV, -64'sd1, 1'b0, 1'b0);      // negative wrap
    endtask

    task automatic t_sat_pos();
        run_op("R3", MAXV, 64'd1, 1'b1, 1'b1);
        run_op("R3", 64'h6000_0000_0000_0000, 64'h6000_0000_0000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_sat_neg();
        run_op("R4", MINV, -64'sd1, 1'b1, 1'b1);
        run_op("R4", 64'hA000_0000_0000_0000, 64'hA000_0000_0000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_advance();
        run_op("R5", 64'h4000_0000_0000_0000, 64'd0, 1'b1, 1'b1);  // adv without ovf
        run_op("R5", -64'sd1, -64'sd1, 1'b0, 1'b0);                // neither flag
        run_op("R5", MAXV, 64'd1, 1'b1, 1'b0);                     // adv from raw sum while clamped
    endtask

    task automatic t_sticky_accum();
        run_op("R6", MAXV, 64'd5, 1'b0, 1'b1);
        run_op("R6", 64'd3, 64'd4, 1'b0, 1'b0);       // sticky_ovf stays set
        run_op("R7", 64'h4000_0000_0000_0000, 64'd1, 1'b0, 1'b1);
        run_op("R7", 64'd1, 64'd1, 1'b0, 1'b0);       // sticky_adv stays set
    endtask

    task automatic t_clear();
        logic [63:0] held;
        run_op("R8", MAXV, 64'd1, 1'b1, 1'b0);
        held = result;
        clr_sticky = 1'b1;
        @(negedge clk);
        clr_sticky = 1'b0;
        m_sov = 1'b0; m_sadv = 1'b0;
        chk1 ("R8", "sticky_ovf after clear", sticky_ovf, 1'b0);
        chk1 ("R8", "sticky_adv after clear", sticky_adv, 1'b0);
        chk1 ("R8", "ovf kept over clear", ovf, 1'b1);
        chk64("R8", "result kept over clear", result, held);
        // clear together with an overflowing operation
        run_op("R8", MINV, MINV, 1'b0, 1'b1);
        // clear together with a clean operation
        run_op("R8", 64'd9, 64'd9, 1'b0, 1'b1);
    endtask

    task automatic t_idle_hold();
        logic [63:0] held;
        run_op("R9", MAXV, 64'd2, 1'b1, 1'b0);
        held = result;
        op_a = 64'd1; op_b = 64'd1; sat_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk1 ("R9", "out_valid idle", out_valid, 1'b0);
        chk64("R9", "result held", result, held);
        chk1 ("R9", "ovf held", ovf, 1'b1);
        chk1 ("R9", "adv held", adv_ovf, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_wrap_plain();
        t_wrap_overflow();
        t_sat_pos();
        t_sat_neg();
        t_advance();
        t_sticky_accum();
        t_clear();
        t_idle_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule